// File: doc/BRIEF.md
# I2C Slave Register Bridge

This block is an I2C bus slave that turns serial transfers into accesses on a simple parallel register bus. It runs entirely on the system clock. SCL and SDA are sampled as ordinary inputs through a synchronizer, and every bus event is recovered from edges of the synchronized levels. On the register side the block drives an address, write data, a one-cycle write strobe, a one-cycle read strobe and a direction flag. It takes read data back from the register bank.

A register write is one transfer: the device address with the write bit, a nonzero register address byte, and then one or more data bytes. Each further data byte goes to the next consecutive address.

A register read takes two transfers. The first is a write transfer whose first payload byte is zero and whose second byte is the register address. The second is a read transfer, after either a stop and a new start or a repeated start. In the read transfer the block returns bytes from consecutive addresses for as long as the master acknowledges them. Because a first byte of zero always means "prepare a read", register address zero can only be written by address wrap-around.

Top module: `i2c_reg_bridge`

## Requirements
- R1: While reset is held, and right after it is released, `sda_oe_n` is 1, `rb_wr` and `rb_rd` are 0, and both `rb_addr` and `rb_dir` are 0.
- R2: The block answers only to an address byte whose upper 7 bits equal `dev_addr`; bit 0 of that byte is the direction, 0 for write and 1 for read. On a mismatch it leaves SDA released during the acknowledge clock and makes no register access until the next start.
- R3: After a matching address byte, and after every byte the master writes, the block holds SDA low (`sda_oe_n`=0, `sda_o`=0) for the whole ninth SCL clock.
- R4: In a write transfer, a nonzero first payload byte becomes the register address. The second payload byte produces exactly one `rb_wr` cycle, with `rb_addr` equal to that address, `rb_wdata` equal to the byte, and `rb_dir`=0.
- R5: Each further payload byte of the same write transfer is written to the previous address plus one, wrapping from 0xFF to 0x00.
- R6: A write transfer whose first payload byte is 0x00 makes no write strobe. Its second byte becomes the address used by the next read transfer.
- R7: A read transfer issues one `rb_rd` cycle with `rb_addr` equal to the current read address and `rb_dir`=1. `rb_rdata` is taken at the clock edge that ends that cycle. The byte is driven on SDA most significant bit first, with each bit changing after an SCL falling edge.
- R8: When the master acknowledges a read byte, the address advances by one and the next byte is fetched and sent. When the master does not acknowledge, SDA is released, no further read strobe is issued, and the block returns to idle.
- R9: A stop condition (SDA rising while SCL is high) returns the block to idle at any point and discards a partly received byte. A start condition (SDA falling while SCL is high), including a repeated start, restarts the address phase.
- R10: `rb_wr` and `rb_rd` are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| dev_addr | input | 7 | 7-bit slave address this block answers to |
| scl_i | input | 1 | Sampled I2C clock line |
| sda_i | input | 1 | Sampled I2C data line |
| sda_o | output | 1 | Value driven onto SDA when enabled |
| sda_oe_n | output | 1 | Active-low SDA output enable |
| rb_addr | output | 8 | Register bus address |
| rb_wdata | output | 8 | Register bus write data |
| rb_wr | output | 1 | One-cycle write strobe |
| rb_rd | output | 1 | One-cycle read strobe |
| rb_dir | output | 1 | Direction of the latest access: 0 write, 1 read |
| rb_rdata | input | 8 | Read data from the register bank, valid while `rb_rd` is high |

## Verification
The hardest state to reach from the ports is an abandoned transfer. This covers a stop that arrives in the middle of a data byte, a repeated start placed directly after the zero-address preparation write, and the end of a read where the master withholds its acknowledge while the block is still holding a prefetched byte. The bench drives its own bit-level master on a wired-AND SDA line. Directed sequences create each of these situations, including an address run that wraps at 0xFF and an address byte that does not match. A seeded random mix of writes, preparation-plus-read sequences and foreign addresses then follows. Every register access is logged from the bus and compared with a pointer model kept in the bench.

// File: rtl/i2c_bridge_pkg.sv
`timescale 1ns/1ps
package i2c_bridge_pkg;

  // Bit-level protocol states of the slave engine.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } slv_state_e;

  localparam int unsigned SLV_ADDR_BITS = 7;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
// Brings SCL/SDA into the clock domain and derives bus events.
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_dly;
  logic              sda_dly;
  logic              scl_s;
  logic              sda_s;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_dly <= 1'b1;
      sda_dly <= 1'b1;
    end else begin
      scl_dly <= scl_s;
      sda_dly <= sda_s;
    end
  end

  always_comb begin
    scl_s      = scl_ff[STAGES-1];
    sda_s      = sda_ff[STAGES-1];
    sda_lvl_o  = sda_s;
    scl_rise_o = scl_s & ~scl_dly;
    scl_fall_o = ~scl_s & scl_dly;
    start_o    = scl_s & scl_dly & sda_dly & ~sda_s;
    stop_o     = scl_s & scl_dly & ~sda_dly & sda_s;
  end

endmodule

// File: rtl/i2c_slave_fsm.sv
`timescale 1ns/1ps
// Bit-level slave engine: address phase, acknowledges, byte shift in/out.
module i2c_slave_fsm
  import i2c_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     sda_lvl_i,
  input  logic [SLV_ADDR_BITS-1:0] dev_addr_i,
  input  logic                     tx_load_i,
  input  logic [DATA_W-1:0]        tx_data_i,
  output logic                     sda_o,
  output logic                     sda_oe_n,
  output logic                     byte_vld_o,
  output logic                     byte_first_o,
  output logic [DATA_W-1:0]        byte_data_o,
  output logic                     fetch_o
);

  localparam int unsigned CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(DATA_W - 1);

  slv_state_e        state_q, state_n;
  logic [CNT_W-1:0]  bit_q, bit_n;
  logic [DATA_W-1:0] rx_q, rx_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic              rw_q, rw_n;
  logic              first_q, first_n;
  logic              nack_q, nack_n;
  logic              vld_q, vld_n;
  logic              vfirst_q, vfirst_n;
  logic [DATA_W-1:0] vdata_q, vdata_n;
  logic              fetch_q, fetch_n;

  // Next-state logic.
  always_comb begin
    state_n  = state_q;
    bit_n    = bit_q;
    rx_n     = rx_q;
    tx_n     = tx_q;
    rw_n     = rw_q;
    first_n  = first_q;
    nack_n   = nack_q;
    vld_n    = 1'b0;
    vfirst_n = vfirst_q;
    vdata_n  = vdata_q;
    fetch_n  = 1'b0;

    if (tx_load_i) begin
      tx_n = tx_data_i;
    end

    if (start_i) begin
      state_n = ST_ADDR;
      bit_n   = '0;
    end else if (stop_i) begin
      state_n = ST_IDLE;
      bit_n   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          bit_n = '0;
        end
        ST_ADDR: begin
          if (scl_rise_i && (bit_q < FULL_CNT)) begin
            rx_n  = {rx_q[DATA_W-2:0], sda_lvl_i};
            bit_n = bit_q + CNT_W'(1);
          end else if (scl_fall_i && (bit_q == FULL_CNT)) begin
            if (rx_q[DATA_W-1:DATA_W-SLV_ADDR_BITS] == dev_addr_i) begin
              state_n = ST_ADDR_ACK;
              rw_n    = rx_q[0];
              fetch_n = rx_q[0];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            bit_n = '0;
            if (rw_q) begin
              state_n = ST_RD_DATA;
            end else begin
              state_n = ST_WR_DATA;
              first_n = 1'b1;
            end
          end
        end
        ST_WR_DATA: begin
          if (scl_rise_i && (bit_q < FULL_CNT)) begin
            rx_n  = {rx_q[DATA_W-2:0], sda_lvl_i};
            bit_n = bit_q + CNT_W'(1);
          end else if (scl_fall_i && (bit_q == FULL_CNT)) begin
            vld_n    = 1'b1;
            vfirst_n = first_q;
            vdata_n  = rx_q;
            first_n  = 1'b0;
            state_n  = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            state_n = ST_WR_DATA;
            bit_n   = '0;
          end
        end
        ST_RD_DATA: begin
          if (scl_fall_i) begin
            if (bit_q == LAST_TX) begin
              state_n = ST_RD_ACK;
              bit_n   = '0;
            end else begin
              tx_n  = {tx_q[DATA_W-2:0], 1'b0};
              bit_n = bit_q + CNT_W'(1);
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) begin
            nack_n  = sda_lvl_i;
            fetch_n = ~sda_lvl_i;
          end else if (scl_fall_i) begin
            bit_n   = '0;
            state_n = nack_q ? ST_IDLE : ST_RD_DATA;
          end
        end
        default: begin
          state_n = ST_IDLE;
        end
      endcase
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      first_q  <= 1'b0;
      nack_q   <= 1'b1;
      vld_q    <= 1'b0;
      vfirst_q <= 1'b0;
      vdata_q  <= '0;
      fetch_q  <= 1'b0;
    end else begin
      state_q  <= state_n;
      bit_q    <= bit_n;
      rx_q     <= rx_n;
      tx_q     <= tx_n;
      rw_q     <= rw_n;
      first_q  <= first_n;
      nack_q   <= nack_n;
      vld_q    <= vld_n;
      vfirst_q <= vfirst_n;
      vdata_q  <= vdata_n;
      fetch_q  <= fetch_n;
    end
  end

  always_comb begin
    sda_oe_n     = ~((state_q == ST_ADDR_ACK) || (state_q == ST_WR_ACK) ||
                     (state_q == ST_RD_DATA));
    sda_o        = (state_q == ST_RD_DATA) ? tx_q[DATA_W-1] : 1'b0;
    byte_vld_o   = vld_q;
    byte_first_o = vfirst_q;
    byte_data_o  = vdata_q;
    fetch_o      = fetch_q;
  end

  // R9: a stop not accompanied by a start always lands in idle.
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> (state_q == ST_IDLE));

  // R2: a foreign address byte ends in idle without any fetch.
  a_r2_mismatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && scl_fall_i && !start_i && !stop_i && bit_q == FULL_CNT &&
     rx_q[DATA_W-1:DATA_W-SLV_ADDR_BITS] != dev_addr_i)
    |=> (state_q == ST_IDLE && !fetch_q));

  // R8: each fetch request is a single pulse.
  a_r8_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_q |=> !fetch_q);

endmodule

// File: rtl/reg_bus_ctrl.sv
`timescale 1ns/1ps
// Interprets received bytes and read requests as register bus accesses.
module reg_bus_ctrl #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic              byte_first_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              fetch_i,
  output logic [DATA_W-1:0] rb_addr_o,
  output logic [DATA_W-1:0] rb_wdata_o,
  output logic              rb_wr_o,
  output logic              rb_rd_o,
  output logic              rb_dir_o
);

  localparam logic [DATA_W-1:0] PREP_CODE = '0;

  logic [DATA_W-1:0] ptr_q, ptr_n;
  logic              prep_q, prep_n;
  logic [DATA_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic              wr_q, wr_n;
  logic              rd_q, rd_n;
  logic              dir_q, dir_n;

  always_comb begin
    ptr_n   = ptr_q;
    prep_n  = prep_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    wr_n    = 1'b0;
    rd_n    = 1'b0;
    dir_n   = dir_q;

    if (byte_vld_i) begin
      if (byte_first_i) begin
        if (byte_data_i == PREP_CODE) begin
          prep_n = 1'b1;
        end else begin
          ptr_n  = byte_data_i;
          prep_n = 1'b0;
        end
      end else if (prep_q) begin
        ptr_n  = byte_data_i;
        prep_n = 1'b0;
      end else begin
        wr_n    = 1'b1;
        addr_n  = ptr_q;
        wdata_n = byte_data_i;
        dir_n   = 1'b0;
        ptr_n   = ptr_q + DATA_W'(1);
      end
    end else if (fetch_i) begin
      rd_n   = 1'b1;
      addr_n = ptr_q;
      dir_n  = 1'b1;
      ptr_n  = ptr_q + DATA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      prep_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      ptr_q   <= ptr_n;
      prep_q  <= prep_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      dir_q   <= dir_n;
    end
  end

  always_comb begin
    rb_addr_o  = addr_q;
    rb_wdata_o = wdata_q;
    rb_wr_o    = wr_q;
    rb_rd_o    = rd_q;
    rb_dir_o   = dir_q;
  end

  // R4: a data byte outside preparation becomes a write at the pointer.
  a_r4_write_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !byte_first_i && !prep_q)
    |=> (rb_wr_o && !rb_dir_o && rb_addr_o == $past(ptr_q)));

  // R6: a zero first byte never produces a write strobe.
  a_r6_prep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && byte_first_i && byte_data_i == PREP_CODE) |=> !rb_wr_o);

  // R7: a fetch request becomes a read strobe on the next cycle.
  a_r7_fetch_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !byte_vld_i) |=> (rb_rd_o && rb_dir_o));

  // R10: strobes exclusive and single-cycle.
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rb_wr_o && rb_rd_o));
  a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    rb_wr_o |=> !rb_wr_o);
  a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rb_rd_o |=> !rb_rd_o);

endmodule

// File: rtl/i2c_reg_bridge.sv
`timescale 1ns/1ps
// I2C slave bridging bus transfers to an 8-bit register bus.
module i2c_reg_bridge
  import i2c_bridge_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLV_ADDR_BITS-1:0] dev_addr,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_o,
  output logic                     sda_oe_n,
  output logic [DATA_W-1:0]        rb_addr,
  output logic [DATA_W-1:0]        rb_wdata,
  output logic                     rb_wr,
  output logic                     rb_rd,
  output logic                     rb_dir,
  input  logic [DATA_W-1:0]        rb_rdata
);

  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_evt;
  logic              stop_evt;
  logic              byte_vld;
  logic              byte_first;
  logic [DATA_W-1:0] byte_data;
  logic              fetch;

  i2c_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_lvl_o  (sda_lvl),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2c_slave_fsm #(
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_evt),
    .stop_i       (stop_evt),
    .sda_lvl_i    (sda_lvl),
    .dev_addr_i   (dev_addr),
    .tx_load_i    (rb_rd),
    .tx_data_i    (rb_rdata),
    .sda_o        (sda_o),
    .sda_oe_n     (sda_oe_n),
    .byte_vld_o   (byte_vld),
    .byte_first_o (byte_first),
    .byte_data_o  (byte_data),
    .fetch_o      (fetch)
  );

  reg_bus_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld_i   (byte_vld),
    .byte_first_i (byte_first),
    .byte_data_i  (byte_data),
    .fetch_i      (fetch),
    .rb_addr_o    (rb_addr),
    .rb_wdata_o   (rb_wdata),
    .rb_wr_o      (rb_wr),
    .rb_rd_o      (rb_rd),
    .rb_dir_o     (rb_dir)
  );

endmodule

// File: tb/i2c_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_bridge_tb_top;

  localparam int Q = 20;
  localparam logic [6:0] SLV = 7'h55;
  localparam int WATCHDOG = 190000;

  logic       clk;
  logic       rst_n;
  logic       m_scl;
  logic       m_sda;
  logic       dut_sda_o;
  logic       dut_oe_n;
  logic [7:0] rb_addr;
  logic [7:0] rb_wdata;
  logic       rb_wr;
  logic       rb_rd;
  logic       rb_dir;
  logic [7:0] rb_rdata;
  logic       sda_line;

  logic [7:0] bank [256];
  logic [7:0] wr_a [256];
  logic [7:0] wr_d [256];
  logic [7:0] rd_a [256];
  int         nwr;
  int         nrd;
  logic       prev_wr;
  logic       prev_rd;
  int         checks;
  int         errors;
  int         cyc;
  logic [7:0] ptr_m;

  assign sda_line = m_sda & (dut_oe_n | dut_sda_o);
  assign rb_rdata = bank[rb_addr];

  i2c_reg_bridge dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (SLV),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_o    (dut_sda_o),
    .sda_oe_n (dut_oe_n),
    .rb_addr  (rb_addr),
    .rb_wdata (rb_wdata),
    .rb_wr    (rb_wr),
    .rb_rd    (rb_rd),
    .rb_dir   (rb_dir),
    .rb_rdata (rb_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    return bank[a];
  endfunction

  // Register bank model and bus logger.
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bank[i] = 8'((i * 7) + 8'h3C);
      nwr = 0;
      nrd = 0;
      prev_wr = 1'b0;
      prev_rd = 1'b0;
    end else begin
      if (rb_wr) begin
        wr_a[nwr % 256] = rb_addr;
        wr_d[nwr % 256] = rb_wdata;
        nwr++;
        bank[rb_addr] = rb_wdata;
        chk(rb_dir == 1'b0, "R4 dir on write", rb_dir, 0);
      end
      if (rb_rd) begin
        rd_a[nrd % 256] = rb_addr;
        nrd++;
        chk(rb_dir == 1'b1, "R7 dir on read", rb_dir, 1);
      end
      if (rb_wr || rb_rd) begin
        // R10 strobe shape
        chk(!(rb_wr && rb_rd) && !(rb_wr && prev_wr) && !(rb_rd && prev_rd),
            "R10 strobe shape", {rb_wr, rb_rd, prev_wr, prev_rd}, 0);
      end
      prev_wr = rb_wr;
      prev_rd = rb_rd;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(2 * Q);
      m_scl = 1'b0; wq(Q);
    end
  endtask

  // Sends one byte; returns the sampled acknowledge level (0 = ACK).
  task automatic send_byte(input logic [7:0] b, output logic ack_lvl, output logic oe_mid);
    send_bits(b, 8);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    ack_lvl = sda_line;
    oe_mid  = dut_oe_n;
    wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(Q);
      m_scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      m_scl = 1'b0; wq(Q);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wq(Q);
    m_scl = 1'b1; wq(2 * Q);
    m_scl = 1'b0; wq(Q);
    m_sda = 1'b1;
  endtask

  task automatic wr_xfer(input logic [7:0] a, input int n, input logic [31:0] dat);
    logic ack, oe;
    int base;
    base = nwr;
    bus_start();
    send_byte({SLV, 1'b0}, ack, oe);
    chk(ack == 1'b0, "R2 address match ack", ack, 0);
    send_byte(a, ack, oe);
    chk(ack == 1'b0 && oe == 1'b0, "R3 ack after address byte", {ack, oe}, 0);
    for (int i = 0; i < n; i++) begin
      send_byte(dat[8*i +: 8], ack, oe);
      chk(ack == 1'b0, "R3 ack after data byte", ack, 0);
    end
    bus_stop();
    wq(8);
    chk(nwr - base == n, "R4 write strobe count", nwr - base, n);
    for (int i = 0; i < n; i++) begin
      chk(wr_a[(base + i) % 256] == 8'(a + i), (i == 0) ? "R4 write address" : "R5 consecutive address",
          wr_a[(base + i) % 256], 8'(a + i));
      chk(wr_d[(base + i) % 256] == dat[8*i +: 8], "R4 write data",
          wr_d[(base + i) % 256], dat[8*i +: 8]);
    end
    ptr_m = 8'(a + n);
  endtask

  task automatic rd_body(input int n);
    logic ack, oe;
    logic [7:0] got;
    logic [7:0] expv [4];
    int base;
    base = nrd;
    for (int i = 0; i < n; i++) expv[i] = exp_rd(8'(ptr_m + i));
    send_byte({SLV, 1'b1}, ack, oe);
    chk(ack == 1'b0, "R2 read address ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, got);
      chk(got == expv[i], "R7 read byte on SDA", got, expv[i]);
    end
    chk(dut_oe_n == 1'b1, "R8 SDA released after NACK", dut_oe_n, 1);
    bus_stop();
    wq(8);
    chk(nrd - base == n, "R8 read strobe count", nrd - base, n);
    for (int i = 0; i < n; i++)
      chk(rd_a[(base + i) % 256] == 8'(ptr_m + i), "R7 read address",
          rd_a[(base + i) % 256], 8'(ptr_m + i));
    ptr_m = 8'(ptr_m + n);
  endtask

  task automatic prep_read(input logic [7:0] p, input bit use_sr, input int n);
    logic ack, oe;
    int base;
    base = nwr;
    bus_start();
    send_byte({SLV, 1'b0}, ack, oe);
    send_byte(8'h00, ack, oe);
    send_byte(p, ack, oe);
    chk(ack == 1'b0, "R3 ack on pointer byte", ack, 0);
    chk(nwr == base, "R6 no write on preparation", nwr - base, 0);
    ptr_m = p;
    if (use_sr) bus_rstart();
    else begin
      bus_stop();
      wq(Q);
      bus_start();
    end
    rd_body(n);
  endtask

  task automatic plain_read(input int n);
    bus_start();
    rd_body(n);
  endtask

  task automatic foreign_xfer(input logic [6:0] other);
    logic ack, oe;
    int bw, br;
    bw = nwr;
    br = nrd;
    bus_start();
    send_byte({other, 1'b0}, ack, oe);
    chk(ack == 1'b1 && oe == 1'b1, "R2 no ack for foreign address", {ack, oe}, 3);
    send_byte(8'h22, ack, oe);
    send_byte(8'h5A, ack, oe);
    chk(ack == 1'b1, "R2 foreign data ignored", ack, 1);
    bus_stop();
    wq(8);
    chk(nwr == bw && nrd == br, "R2 no access on foreign address", (nwr - bw) + (nrd - br), 0);
  endtask

  initial begin
    logic ack, oe;
    checks = 0;
    errors = 0;
    cyc    = 0;
    m_scl  = 1'b1;
    m_sda  = 1'b1;
    rst_n  = 1'b0;
    ptr_m  = 8'h00;
    void'($urandom(32'h5EED1234));
    wq(6);
    chk(dut_oe_n == 1'b1 && rb_wr == 1'b0 && rb_rd == 1'b0, "R1 strobes and SDA in reset",
        {dut_oe_n, rb_wr, rb_rd}, 4);
    rst_n = 1'b1;
    wq(4);
    chk(rb_addr == 8'h00 && rb_dir == 1'b0 && dut_oe_n == 1'b1, "R1 state after reset",
        {rb_addr, rb_dir, dut_oe_n}, 1);

    // Directed cases.
    wr_xfer(8'h10, 2, 32'h0000_B7A1);             // R4, R5
    wr_xfer(8'hFF, 3, 32'h0033_2211);             // R5 wrap at 0xFF
    prep_read(8'h10, 1'b1, 3);                    // R6, R7, R8 with repeated start
    prep_read(8'hFE, 1'b0, 3);                    // R8 read wraps, stop then start
    foreign_xfer(7'h2A);                          // R2
    wr_xfer(8'h80, 1, 32'h0000_00C3);
    plain_read(2);                                // R8 continues from 0x81

    // R9: stop in the middle of a data byte.
    begin
      int base;
      base = nwr;
      bus_start();
      send_byte({SLV, 1'b0}, ack, oe);
      send_byte(8'h60, ack, oe);
      send_bits(8'hA5, 3);
      bus_stop();
      wq(8);
      chk(nwr == base, "R9 partial byte discarded", nwr - base, 0);
      chk(dut_oe_n == 1'b1, "R9 idle after stop", dut_oe_n, 1);
      ptr_m = 8'h60;
      plain_read(1);
    end

    // R9: repeated start in the middle of a write restarts the address phase.
    begin
      int base;
      base = nwr;
      bus_start();
      send_byte({SLV, 1'b0}, ack, oe);
      send_byte(8'h70, ack, oe);
      send_bits(8'hFF, 4);
      bus_rstart();
      chk(nwr == base, "R9 repeated start no write", nwr - base, 0);
      ptr_m = 8'h70;
      rd_body(1);
    end

    // Seeded random mix.
    for (int it = 0; it < 14; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0, 1: wr_xfer(8'($urandom_range(1, 255)), $urandom_range(1, 3), $urandom());
        2:    prep_read(8'($urandom_range(0, 255)), $urandom_range(0, 1) == 1, $urandom_range(1, 3));
        default: foreign_xfer(7'($urandom_range(0, 126)) ^ 7'h00 | 7'h00 == 7'h55 ? 7'h11 :
                              ((7'($urandom_range(0, 126)) == SLV) ? 7'h11 : 7'h2B));
      endcase
    end

    wq(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule